// File: doc/BRIEF.md
# Quarter-Wave Sine Excitation Generator

This block produces the digital primary excitation for a position-sensor front end: a signed 16-bit sine sample stream built from a phase accumulator and a lookup table that stores only the first quarter of a cycle. The other three quarters come from the same table. In the second and fourth quarters the table address is folded, and in the third and fourth quarters the sign of the output is flipped. The generator runs at a fixed sample rate given by a sample-enable pulse, for example 160 kHz. With a tuning word of 2^28 this gives a 10 kHz carrier with sixteen samples per period.

Software or a sequencer can present a new tuning word and a new phase offset at any time. Neither is used until the hop strobe is pulsed. The strobe copies both into the active registers, and the next sample uses them. A frequency change keeps the running accumulator, so the phase does not jump. A phase change moves the lookup point by the offset, which is added to the accumulator and never stored into it. After reset the accumulator, tuning word and offset are all zero, so the first sample is zero.

Top module: `exc_wavegen`

## Requirements
- R1: Reset (synchronous, active high) clears the output, accumulator, active tuning word and active offset. Samples taken before any hop therefore all read 0.
- R2: On each edge with `smp_en` high, the output becomes the sine of (accumulator + active offset), and the accumulator then advances by the active tuning word. Sample n after reset is wave(n*F + P).
- R3: On an edge with `smp_en` low, the output and the accumulator keep their values.
- R4: `freq_word` and `phase_ofs` have no effect unless `hop` is high at that edge.
- R5: A hop on the same edge as a sample does not alter that sample. The new values apply from the next sample onward.
- R6: Phase bits [PHASE_W-1:PHASE_W-2] select the quadrant. Codes 01 and 11 read the table at N-k instead of k, and codes 10 and 11 negate the output. wave(P) therefore equals wave(2^(PHASE_W-1) - P) exactly for grid-aligned P.
- R7: Let N = 2^LUT_AW and let k be phase bits [PHASE_W-3 : PHASE_W-2-LUT_AW]. The table value is round(AMP*sin(pi/2*k/N)). The peak entry k = N equals AMP exactly, and phase 0 gives 0.
- R8: The phase offset shifts only the lookup point. Hopping the offset back to 0 returns the output to the plain accumulator phase.
- R9: A frequency hop leaves the accumulator untouched, so the phase sequence stays continuous across the change.
- R10: The output stays within [-AMP, AMP], and samples half a cycle apart are exact negatives of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample enable: produce one sample and advance the phase |
| hop | input | 1 | Strobe that loads `freq_word` and `phase_offset` into the active registers |
| freq_word | input | PHASE_W | Pending tuning word (phase step per sample) |
| phase_ofs | input | PHASE_W | Pending phase offset |
| wave_o | output | OUT_W | Signed sine sample |

## Verification
The bench builds the block with a 32-bit phase, a 32-entry quarter table and an amplitude of 32767. This keeps the whole 128-point cycle small enough that chosen phase offsets land exactly on table points. At those points folding symmetry, odd symmetry and the exact peak value can be compared bit for bit, and other points are compared against a real-valued sine within one LSB. A tuning word of 2^28 reproduces the 10 kHz at 160 kHz case. The bench also times hops against samples to cover the same-edge case.

// File: rtl/exc_wave_pkg.sv
package exc_wave_pkg;

  // Quadrant code taken from the two phase MSBs
  typedef enum logic [1:0] {
    QD_RISE  = 2'b00,
    QD_FALL  = 2'b01,
    QD_NRISE = 2'b10,
    QD_NFALL = 2'b11
  } quad_e;

  // pi scaled by 2^30
  localparam longint PI_Q30 = 64'sd3373259426;

  // round(amp * sin(pi/2 * k / n)) computed with an integer series in Q30
  function automatic longint qsine_fix(input int k, input int n, input int amp);
    longint x;
    longint term;
    longint sum;
    longint r;
    x    = (longint'(k) * PI_Q30) / (longint'(2) * longint'(n));
    term = x;
    sum  = x;
    for (int i = 1; i <= 6; i++) begin
      term = (term * x) >>> 30;
      term = (term * x) >>> 30;
      term = -(term / (longint'(2 * i) * longint'(2 * i + 1)));
      sum  = sum + term;
    end
    r = (sum * longint'(amp) + (longint'(1) <<< 29)) >>> 30;
    if (r > longint'(amp)) r = longint'(amp);
    if (r < 0) r = 0;
    return r;
  endfunction

endpackage

// File: rtl/exc_phase_core.sv
module exc_phase_core #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_en,
  input  logic               hop,
  input  logic [PHASE_W-1:0] fw_in,
  input  logic [PHASE_W-1:0] po_in,
  output logic [PHASE_W-1:0] acc_o,
  output logic [PHASE_W-1:0] act_fw_o,
  output logic [PHASE_W-1:0] act_po_o,
  output logic [PHASE_W-1:0] look_ph_o
);

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] fw_q;
  logic [PHASE_W-1:0] po_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      fw_q  <= '0;
      po_q  <= '0;
    end else begin
      if (smp_en) acc_q <= acc_q + fw_q;
      if (hop) begin
        fw_q <= fw_in;
        po_q <= po_in;
      end
    end
  end

  assign acc_o     = acc_q;
  assign act_fw_o  = fw_q;
  assign act_po_o  = po_q;
  assign look_ph_o = acc_q + po_q;

endmodule

// File: rtl/exc_quad_map.sv
module exc_quad_map
  import exc_wave_pkg::*;
#(
  parameter int LUT_AW = 5
) (
  input  logic [LUT_AW+1:0] ph_top,
  output logic [LUT_AW:0]   rom_addr,
  output logic              mirror,
  output logic              neg
);

  localparam int N = 1 << LUT_AW;

  quad_e             quad;
  logic [LUT_AW-1:0] idx;

  function automatic logic [LUT_AW:0] fold_addr(input logic [LUT_AW-1:0] i, input logic m);
    logic [LUT_AW:0] wide;
    wide = {1'b0, i};
    return m ? ((LUT_AW+1)'(N) - wide) : wide;
  endfunction

  assign quad     = quad_e'(ph_top[LUT_AW+1 -: 2]);
  assign idx      = ph_top[LUT_AW-1:0];
  assign mirror   = (quad == QD_FALL) || (quad == QD_NFALL);
  assign neg      = (quad == QD_NRISE) || (quad == QD_NFALL);
  assign rom_addr = fold_addr(idx, mirror);

endmodule

// File: rtl/exc_qtable.sv
module exc_qtable
  import exc_wave_pkg::*;
#(
  parameter int LUT_AW = 5,
  parameter int OUT_W  = 16,
  parameter int AMP    = 32767
) (
  input  logic [LUT_AW:0]  addr,
  output logic [OUT_W-1:0] mag
);

  localparam int N = 1 << LUT_AW;
  localparam logic [OUT_W-1:0] PEAK = OUT_W'(AMP);

  logic [OUT_W-1:0] rom [N];

  for (genvar g = 0; g < N; g++) begin : g_rom
    localparam longint VAL = qsine_fix(g, N, AMP);
    assign rom[g] = OUT_W'(VAL);
  end

  // Only address N has the top bit set: it is the quarter-cycle peak
  assign mag = addr[LUT_AW] ? PEAK : rom[addr[LUT_AW-1:0]];

endmodule

// File: rtl/exc_wavegen.sv
module exc_wavegen #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 5,
  parameter int OUT_W   = 16,
  parameter int AMP     = 32767
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_en,
  input  logic                    hop,
  input  logic [PHASE_W-1:0]      freq_word,
  input  logic [PHASE_W-1:0]      phase_ofs,
  output logic signed [OUT_W-1:0] wave_o
);

  localparam int TOP_W = LUT_AW + 2;

  logic [PHASE_W-1:0]      acc_w;
  logic [PHASE_W-1:0]      act_fw;
  logic [PHASE_W-1:0]      act_po;
  logic [PHASE_W-1:0]      look_ph;
  logic [LUT_AW:0]         rom_addr;
  logic                    mirror_flag;
  logic                    neg_flag;
  logic [OUT_W-1:0]        mag;
  logic signed [OUT_W-1:0] wave_d;

  function automatic logic signed [OUT_W-1:0] apply_sign(input logic [OUT_W-1:0] m, input logic n);
    return n ? -$signed(m) : $signed(m);
  endfunction

  exc_phase_core #(.PHASE_W(PHASE_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .smp_en   (smp_en),
    .hop      (hop),
    .fw_in    (freq_word),
    .po_in    (phase_ofs),
    .acc_o    (acc_w),
    .act_fw_o (act_fw),
    .act_po_o (act_po),
    .look_ph_o(look_ph)
  );

  exc_quad_map #(.LUT_AW(LUT_AW)) u_map (
    .ph_top  (look_ph[PHASE_W-1 -: TOP_W]),
    .rom_addr(rom_addr),
    .mirror  (mirror_flag),
    .neg     (neg_flag)
  );

  exc_qtable #(.LUT_AW(LUT_AW), .OUT_W(OUT_W), .AMP(AMP)) u_tab (
    .addr(rom_addr),
    .mag (mag)
  );

  assign wave_d = apply_sign(mag, neg_flag);

  always_ff @(posedge clk) begin
    if (rst)         wave_o <= '0;
    else if (smp_en) wave_o <= wave_d;
  end

endmodule

// File: rtl/exc_wavegen_chk.sv
module exc_wavegen_chk #(
  parameter int PHASE_W = 32,
  parameter int OUT_W   = 16,
  parameter int AMP     = 32767
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    smp_en,
  input logic                    hop,
  input logic                    neg_flag,
  input logic                    mirror_flag,
  input logic [PHASE_W-1:0]      acc,
  input logic [PHASE_W-1:0]      act_fw,
  input logic [PHASE_W-1:0]      act_po,
  input logic [PHASE_W-1:0]      look_ph,
  input logic signed [OUT_W-1:0] wave_o
);

  // R1: reset clears output and accumulator
  p_rst_clear_r1: assert property (@(posedge clk) rst |=> (wave_o == '0 && acc == '0));

  // R3: no sample, no change of output
  p_hold_out_r3: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(wave_o));

  // R3: no sample, no change of accumulator (also covers R9: hop alone keeps it)
  p_hold_acc_r3: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(acc));

  // R4: pending words are ignored without a hop strobe
  p_cfg_gate_r4: assert property (@(posedge clk) disable iff (rst)
    !hop |=> ($stable(act_fw) && $stable(act_po)));

  // R6: positive half of the cycle never yields a negative sample
  p_pos_half_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_en && !neg_flag) |=> (wave_o >= 0));

  // R6: negative half of the cycle never yields a positive sample
  p_neg_half_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_en && neg_flag) |=> (wave_o <= 0));

  // R7: phase exactly zero gives a zero sample
  p_zero_phase_r7: assert property (@(posedge clk) disable iff (rst)
    (smp_en && look_ph == '0 && !mirror_flag) |=> (wave_o == '0));

  // R10: amplitude bound
  p_range_r10: assert property (@(posedge clk) disable iff (rst)
    (wave_o <= OUT_W'(AMP)) && (wave_o >= -OUT_W'(AMP)));

endmodule

bind exc_wavegen exc_wavegen_chk #(
  .PHASE_W(PHASE_W),
  .OUT_W  (OUT_W),
  .AMP    (AMP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_en     (smp_en),
  .hop        (hop),
  .neg_flag   (neg_flag),
  .mirror_flag(mirror_flag),
  .acc        (acc_w),
  .act_fw     (act_fw),
  .act_po     (act_po),
  .look_ph    (look_ph),
  .wave_o     (wave_o)
);

// File: tb/sim_exc_wavegen.sv
module sim_exc_wavegen;

  localparam int PW  = 32;
  localparam int AW  = 5;
  localparam int OW  = 16;
  localparam int AMP = 32767;
  localparam int NQ  = 1 << AW;
  localparam real PI = 3.14159265358979;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 smp_en = 1'b0;
  logic                 hop = 1'b0;
  logic [PW-1:0]        fw_i = '0;
  logic [PW-1:0]        po_i = '0;
  logic signed [OW-1:0] wave;

  exc_wavegen #(.PHASE_W(PW), .LUT_AW(AW), .OUT_W(OW), .AMP(AMP)) u0 (
    .clk(clk), .rst(rst), .smp_en(smp_en), .hop(hop),
    .freq_word(fw_i), .phase_ofs(po_i), .wave_o(wave)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [PW-1:0] m_acc = '0;
  logic [PW-1:0] m_fw  = '0;
  logic [PW-1:0] m_po  = '0;
  int m_exp = 0;

  // Reference: sine of the quantized phase over the whole cycle
  function automatic int ref_wave(input logic [PW-1:0] ph);
    int  j;
    real r;
    j = int'(ph >> (PW - AW - 2));
    r = AMP * $sin(2.0 * PI * j / (4.0 * NQ));
    if (r >= 0.0) return int'($floor(r + 0.5));
    else          return -int'($floor(-r + 0.5));
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, model the edge, settle before returning
  task automatic cyc(input bit s, input bit h, input logic [PW-1:0] f, input logic [PW-1:0] p);
    @(negedge clk);
    smp_en = s; hop = h; fw_i = f; po_i = p;
    @(posedge clk);
    if (s) begin
      m_exp = ref_wave(m_acc + m_po);
      m_acc = m_acc + m_fw;
    end
    if (h) begin
      m_fw = f;
      m_po = p;
    end
    #5;
  endtask

  task automatic smp();
    cyc(1'b1, 1'b0, fw_i, po_i);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) cyc(1'b0, 1'b0, '0, '0);
    chk("R1 output in reset", int'(wave), 0, 0);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      smp();
      chk("R1 sample before any hop", int'(wave), 0, 0);
    end
  endtask

  task automatic t_basic();
    cyc(1'b0, 1'b1, 32'h1000_0000, '0);
    for (int i = 0; i < 16; i++) begin
      smp();
      chk("R2/R7 10kHz sequence", int'(wave), m_exp, 1);
    end
  endtask

  task automatic t_hold();
    int w;
    w = int'(wave);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b0, 32'h0BAD_F00D + i, 32'h1234_5678);
      chk("R3 hold without sample", int'(wave), w, 0);
    end
  endtask

  task automatic t_ignore();
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, 1'b0, 32'h0777_0000, 32'h4000_0000);
      chk("R4 pending words ignored", int'(wave), m_exp, 1);
    end
  endtask

  task automatic t_same_edge();
    cyc(1'b1, 1'b1, 32'h0125_4321, 32'h0);
    chk("R5 same-edge sample uses old word", int'(wave), m_exp, 1);
    for (int i = 0; i < 5; i++) begin
      smp();
      chk("R5/R9 new word after hop", int'(wave), m_exp, 1);
    end
  endtask

  task automatic t_offset();
    cyc(1'b0, 1'b1, m_fw, 32'h4000_0000);
    for (int i = 0; i < 3; i++) begin
      smp();
      chk("R8 offset applied", int'(wave), m_exp, 1);
    end
    cyc(1'b0, 1'b1, m_fw, 32'h0);
    for (int i = 0; i < 3; i++) begin
      smp();
      chk("R8 offset removed, plain phase", int'(wave), ref_wave(m_acc - m_fw), 1);
    end
  endtask

  task automatic t_freq_hop();
    cyc(1'b0, 1'b1, 32'h0300_0000, m_po);
    for (int i = 0; i < 4; i++) begin
      smp();
      chk("R9 continuous phase after hop", int'(wave), m_exp, 1);
    end
  endtask

  task automatic t_mirror();
    logic [PW-1:0] p;
    int s0;
    int s1;
    int a;
    int b;
    p = 32'd5 << (PW - AW - 2);
    cyc(1'b0, 1'b1, 32'h8000_0000 - (p << 1), p - m_acc);
    smp(); s0 = int'(wave);
    chk("R7 grid point value", s0, ref_wave(p), 1);
    smp(); s1 = int'(wave);
    chk("R6 fold exact", s1, s0, 0);
    cyc(1'b0, 1'b1, 32'h8000_0000, m_po);
    smp(); a = int'(wave);
    smp(); b = int'(wave);
    chk("R10 half-cycle negation exact", b, -a, 0);
    chk("R6 third/fourth quarter sign", a, m_exp * -1, 1);
  endtask

  task automatic t_peak();
    cyc(1'b0, 1'b1, 32'h8000_0000, 32'h4000_0000 - m_acc);
    smp();
    chk("R7 peak equals AMP", int'(wave), AMP, 0);
    smp();
    chk("R10 trough equals -AMP", int'(wave), -AMP, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_hold();
    t_ignore();
    t_same_edge();
    t_offset();
    t_freq_hop();
    t_mirror();
    t_peak();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule